// File: doc/BRIEF.md
# Dual-Threshold Time-Over-Threshold Hit Recorder

This block digitises strip-detector hits for a group of eight channels. Each channel drives two comparator lines into the block. The read line switches at a low threshold. The qualify line switches at a higher threshold. Both lines are asynchronous, so each passes through a two-flop synchronizer. A fast clock then scans the channels, one per cycle, in a fixed eight-slot rotation. One full rotation is a coarse tick, and a twelve-bit event-time counter counts these ticks.

A pulse starts when a channel's read line is first seen high. The pulse is kept only if the qualify line is seen high on a sample where the read line is also high. Its width is the number of coarse samples on which the read line stayed high. When the pulse ends, a kept pulse becomes two records, pushed together into one FIFO: a leading record with the start time and a trailing record with the end time and the width. A pulse that never ends is cut off at a saturation limit. The channel then needs a new rising edge before it can record again.

A downstream reader drains the FIFO one record per cycle with a pop strobe. A sticky flag marks any record pair that was lost because the FIFO was full.

Top module: `tot_hit_recorder`

## Requirements
- R1: Both comparator inputs of every channel pass through two synchronizer flops. An input set before fast clock edge e is first used by the scan at edge e+2.
- R2: The channel logic sees a rising edge when the synchronized read line is high on a channel's sample and was low on its previous sample. The pulse start time is the event time of that sample. The leading record carries edge bit 0, width 0 and saturation flag 0.
- R3: A pulse is kept only if the synchronized qualify line is high on a sample where the read line is also high. Otherwise no record of that pulse is written.
- R4: A pulse ends on the first sample where the read line is low. The trailing record carries edge bit 1 and the event time of that sample. Its width equals the number of high samples, which is also end time minus start time. A pulse seen on a single sample has width 1.
- R5: A pulse ends by saturation on a sample where the read line is high and 255 high samples have already been counted. Its trailing record has the saturation flag set to 1 and width 255. The channel then writes nothing more until its read line goes low and rises again.
- R6: The leading and trailing records of one pulse are written in the same cycle, next to each other, leading first. Both carry the channel number.
- R7: A pulse pair is written only if the FIFO has at least two free entries before that cycle. Otherwise the pair is dropped entirely and the overflow flag is set. The flag stays set until reset.
- R8: Channel c (0 to 7) is sampled on scan slot c. After reset the slot and the event time both start at 0. One slot passes per fast cycle. The event time increments after slot 7 and wraps modulo 4096.
- R9: While the FIFO is not empty, rec_valid is 1 and the outputs show the oldest record, held steady. Asserting rd_en pops it at the next edge.
- R10: Reset is synchronous and active high. It empties the FIFO, clears the overflow flag and clears all channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast scan clock, one channel slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmp_lo | input | 8 | Low (read) threshold comparator per channel, asynchronous |
| cmp_hi | input | 8 | High (qualify) threshold comparator per channel, asynchronous |
| rd_en | input | 1 | Pop the head record at the next edge |
| rec_valid | output | 1 | FIFO holds at least one record |
| rec_chan | output | 3 | Channel number of the head record |
| rec_trail | output | 1 | Edge bit: 0 leading, 1 trailing |
| rec_time | output | 12 | Event-time stamp in coarse ticks |
| rec_width | output | 8 | Pulse width in ticks (0 on leading records) |
| rec_sat | output | 1 | Width saturated at 255 |
| overflow | output | 1 | Sticky: a record pair was dropped |

## Verification
Some properties are checked by assertions on every cycle, at the read port:
- a leading record is always followed at once by its trailing partner on the same channel;
- leading records have zero width;
- the saturation flag implies width 255;
- a trailing stamp minus its leading stamp equals the width;
- the head record holds steady while it is not popped;
- overflow never clears.

Only the bench scenarios show which pulses are kept or discarded, the exact start ticks set by synchronizer latency and slot position, single-sample widths, and re-arming after saturation. They also show that exactly a full FIFO's worth of pairs survives when the FIFO fills.

// File: rtl/tot_pkg.sv
package tot_pkg;

    localparam int NCH  = 8;
    localparam int CH_W = $clog2(NCH);
    localparam int TS_W = 12;
    localparam int WD_W = 8;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            trail;
        logic [TS_W-1:0] stamp;
        logic [WD_W-1:0] width;
        logic            sat;
    } hit_rec_t;

    function automatic hit_rec_t make_lead(logic [CH_W-1:0] ch, logic [TS_W-1:0] ts);
        hit_rec_t r;
        r.chan  = ch;
        r.trail = 1'b0;
        r.stamp = ts;
        r.width = '0;
        r.sat   = 1'b0;
        return r;
    endfunction

    function automatic hit_rec_t make_trail(logic [CH_W-1:0] ch, logic [TS_W-1:0] ts,
                                            logic [WD_W-1:0] w, logic s);
        hit_rec_t r;
        r.chan  = ch;
        r.trail = 1'b1;
        r.stamp = ts;
        r.width = w;
        r.sat   = s;
        return r;
    endfunction

endpackage

// File: rtl/tot_sync.sv
module tot_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= din[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/tot_scan_timer.sv
module tot_scan_timer
    import tot_pkg::*;
#(
    parameter int NSLOT = NCH
) (
    input  logic            clk,
    input  logic            rst,
    output logic [CH_W-1:0] slot,
    output logic [TS_W-1:0] tick
);
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NSLOT - 1);

    logic [CH_W-1:0] slot_q;
    logic [TS_W-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            tick_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
            tick_q <= tick_q + TS_W'(1);
        end else begin
            slot_q <= slot_q + CH_W'(1);
        end
    end

    assign slot = slot_q;
    assign tick = tick_q;
endmodule

// File: rtl/tot_chan_engine.sv
module tot_chan_engine
    import tot_pkg::*;
#(
    parameter int NSLOT   = NCH,
    parameter int SAT_LIM = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] lo_s,
    input  logic [NSLOT-1:0] hi_s,
    input  logic [CH_W-1:0]  slot,
    input  logic [TS_W-1:0]  tick,
    output logic             emit,
    output hit_rec_t         lead_rec,
    output hit_rec_t         trail_rec
);
    localparam logic [WD_W-1:0] SAT_W = WD_W'(SAT_LIM);

    logic [NSLOT-1:0] act_q;
    logic [NSLOT-1:0] prv_q;
    logic [NSLOT-1:0] hit_q;
    logic [WD_W-1:0]  cnt_q  [NSLOT];
    logic [TS_W-1:0]  lead_q [NSLOT];

    logic            cur_lo, cur_hi, cur_act, cur_hit;
    logic [WD_W-1:0] cur_cnt;
    logic            start_p, fall_p, sat_p;

    always_comb begin
        cur_lo   = lo_s[slot];
        cur_hi   = hi_s[slot];
        cur_act  = act_q[slot];
        cur_hit  = hit_q[slot];
        cur_cnt  = cnt_q[slot];
        start_p  = !cur_act && cur_lo && !prv_q[slot];
        fall_p   = cur_act && !cur_lo;
        sat_p    = cur_act && cur_lo && (cur_cnt == SAT_W);
        emit     = (fall_p && cur_hit) || (sat_p && (cur_hit || cur_hi));
        lead_rec  = make_lead(slot, lead_q[slot]);
        trail_rec = make_trail(slot, tick, cur_cnt, sat_p);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            prv_q <= '0;
            hit_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                cnt_q[i]  <= '0;
                lead_q[i] <= '0;
            end
        end else begin
            prv_q[slot] <= cur_lo;
            if (start_p) begin
                act_q[slot]  <= 1'b1;
                hit_q[slot]  <= cur_hi;
                cnt_q[slot]  <= WD_W'(1);
                lead_q[slot] <= tick;
            end else if (fall_p || sat_p) begin
                act_q[slot] <= 1'b0;
            end else if (cur_act) begin
                cnt_q[slot] <= cur_cnt + WD_W'(1);
                hit_q[slot] <= cur_hit | cur_hi;
            end
        end
    end
endmodule

// File: rtl/tot_pair_fifo.sv
module tot_pair_fifo
    import tot_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_pair,
    input  hit_rec_t rec_a,
    input  hit_rec_t rec_b,
    input  logic     rd_en,
    output hit_rec_t head,
    output logic     valid,
    output logic     ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] ROOM_MAX = (AW+1)'(DEPTH - 2);

    hit_rec_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt_q;
    logic          ovf_q;
    logic          has_room, do_wr, do_rd;

    always_comb begin
        has_room = (cnt_q <= ROOM_MAX);
        do_wr    = wr_pair && has_room;
        do_rd    = rd_en && (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr]           <= rec_a;
            mem[wr_ptr + AW'(1)]  <= rec_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(2);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            cnt_q <= cnt_q + (do_wr ? (AW+1)'(2) : '0) - (do_rd ? (AW+1)'(1) : '0);
            if (wr_pair && !has_room) ovf_q <= 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign valid = (cnt_q != '0);
    assign ovf   = ovf_q;
endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder
    import tot_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int SAT_LIM = 255
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  cmp_lo,
    input  logic [NCH-1:0]  cmp_hi,
    input  logic            rd_en,
    output logic            rec_valid,
    output logic [CH_W-1:0] rec_chan,
    output logic            rec_trail,
    output logic [TS_W-1:0] rec_time,
    output logic [WD_W-1:0] rec_width,
    output logic            rec_sat,
    output logic            overflow
);
    logic [NCH-1:0]  lo_s, hi_s;
    logic [CH_W-1:0] slot;
    logic [TS_W-1:0] tick;
    logic            emit;
    hit_rec_t        lead_rec, trail_rec, head;

    tot_sync #(.W(NCH)) u_sync_lo (.clk(clk), .rst(rst), .din(cmp_lo), .dout(lo_s));
    tot_sync #(.W(NCH)) u_sync_hi (.clk(clk), .rst(rst), .din(cmp_hi), .dout(hi_s));

    tot_scan_timer #(.NSLOT(NCH)) u_timer (
        .clk(clk), .rst(rst), .slot(slot), .tick(tick)
    );

    tot_chan_engine #(.NSLOT(NCH), .SAT_LIM(SAT_LIM)) u_engine (
        .clk(clk), .rst(rst), .lo_s(lo_s), .hi_s(hi_s), .slot(slot), .tick(tick),
        .emit(emit), .lead_rec(lead_rec), .trail_rec(trail_rec)
    );

    tot_pair_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wr_pair(emit), .rec_a(lead_rec), .rec_b(trail_rec),
        .rd_en(rd_en), .head(head), .valid(rec_valid), .ovf(overflow)
    );

    assign rec_chan  = head.chan;
    assign rec_trail = head.trail;
    assign rec_time  = head.stamp;
    assign rec_width = head.width;
    assign rec_sat   = head.sat;
endmodule

// File: rtl/tot_hit_recorder_chk.sv
module tot_hit_recorder_chk
    import tot_pkg::*;
#(
    parameter int SAT_LIM = 255
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_en,
    input logic            rec_valid,
    input logic [CH_W-1:0] rec_chan,
    input logic            rec_trail,
    input logic [TS_W-1:0] rec_time,
    input logic [WD_W-1:0] rec_width,
    input logic            rec_sat,
    input logic            overflow
);
    logic [TS_W-1:0] lead_t;
    logic            lead_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_t    <= '0;
            lead_seen <= 1'b0;
        end else if (rd_en && rec_valid && !rec_trail) begin
            lead_t    <= rec_time;
            lead_seen <= 1'b1;
        end
    end

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(overflow)) |-> overflow);

    // R6
    pair_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rec_valid && !rec_trail) |=>
        (rec_valid && rec_trail && rec_chan == $past(rec_chan)));

    // R2
    lead_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_trail) |-> (rec_width == '0 && !rec_sat));

    // R5
    sat_width_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_sat) |-> (rec_trail && rec_width == WD_W'(SAT_LIM)));

    // R4
    trail_span_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_trail && lead_seen) |->
        (rec_width != '0 && (rec_time - lead_t) == TS_W'(rec_width)));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rec_valid) && !$past(rd_en) && !$past(rst)) |->
        (rec_valid && $stable(rec_time) && $stable(rec_chan) && $stable(rec_trail)
         && $stable(rec_width)));
endmodule

bind tot_hit_recorder tot_hit_recorder_chk #(.SAT_LIM(SAT_LIM)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rec_valid(rec_valid), .rec_chan(rec_chan),
    .rec_trail(rec_trail), .rec_time(rec_time), .rec_width(rec_width),
    .rec_sat(rec_sat), .overflow(overflow)
);

// File: tb/sim_tot_hit_recorder.sv
module sim_tot_hit_recorder;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 8;
    localparam int DEPTH = 16;
    localparam int SAT   = 255;

    typedef struct {
        int ch;
        bit tr;
        int ts;
        int w;
        bit s;
    } mrec_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] lo_in = '0;
    logic [N-1:0] hi_in = '0;
    logic         rd_en = 1'b0;
    logic         rec_valid, rec_trail, rec_sat, overflow;
    logic [2:0]   rec_chan;
    logic [11:0]  rec_time;
    logic [7:0]   rec_width;

    int nvec  = 0;
    int nfail = 0;

    tot_hit_recorder u0 (
        .clk(clk), .rst(rst), .cmp_lo(lo_in), .cmp_hi(hi_in), .rd_en(rd_en),
        .rec_valid(rec_valid), .rec_chan(rec_chan), .rec_trail(rec_trail),
        .rec_time(rec_time), .rec_width(rec_width), .rec_sat(rec_sat),
        .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    mrec_t  mq[$];
    mrec_t  plog[$];
    bit     m_ovf;
    int     m_slot, m_tick, ecount;
    bit [N-1:0] dl1, dl2, dh1, dh2;
    bit     m_on[N];
    bit     m_seen[N];
    bit     m_prev[N];
    int     m_len[N];
    int     m_start[N];

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_ovf = 0; m_slot = 0; m_tick = 0; ecount = 0;
            dl1 = '0; dl2 = '0; dh1 = '0; dh2 = '0;
            for (int i = 0; i < N; i++) begin
                m_on[i] = 0; m_seen[i] = 0; m_prev[i] = 0; m_len[i] = 0; m_start[i] = 0;
            end
        end else begin
            int  c, width, sz;
            bit  lo, hi, emit, sat;
            if (rd_en && rec_valid)
                plog.push_back('{int'(rec_chan), rec_trail, int'(rec_time), int'(rec_width), rec_sat});
            c = m_slot; lo = dl2[c]; hi = dh2[c];
            emit = 0; sat = 0; width = 0;
            if (m_on[c]) begin
                if (!lo) begin
                    emit = m_seen[c]; width = m_len[c]; m_on[c] = 0;
                end else if (m_len[c] == SAT) begin
                    emit = m_seen[c] || hi; sat = 1; width = SAT; m_on[c] = 0;
                end else begin
                    m_len[c]++; m_seen[c] = m_seen[c] || hi;
                end
            end else if (lo && !m_prev[c]) begin
                m_on[c] = 1; m_len[c] = 1; m_seen[c] = hi; m_start[c] = m_tick;
            end
            m_prev[c] = lo;
            sz = mq.size();
            if (rd_en && sz > 0) void'(mq.pop_front());
            if (emit) begin
                if (DEPTH - sz >= 2) begin
                    mq.push_back('{c, 1'b0, m_start[c], 0, 1'b0});
                    mq.push_back('{c, 1'b1, m_tick, width, sat});
                end else m_ovf = 1;
            end
            dl2 = dl1; dl1 = lo_in; dh2 = dh1; dh1 = hi_in;
            m_slot++;
            if (m_slot == N) begin m_slot = 0; m_tick = (m_tick + 1) % 4096; end
            ecount++;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            bit mv;
            nvec++;
            mv = (mq.size() != 0);
            if (rec_valid !== mv) begin
                nfail++; $display("FAIL R9 rec_valid act=%0b exp=%0b", rec_valid, mv);
            end else if (mv) begin
                if (int'(rec_chan) != mq[0].ch || rec_trail != mq[0].tr) begin
                    nfail++;
                    $display("FAIL R6 chan/edge act=%0d/%0b exp=%0d/%0b",
                             rec_chan, rec_trail, mq[0].ch, mq[0].tr);
                end
                if (int'(rec_time) != mq[0].ts) begin
                    nfail++; $display("FAIL R8 time act=%0d exp=%0d", rec_time, mq[0].ts);
                end
                if (int'(rec_width) != mq[0].w) begin
                    nfail++; $display("FAIL R4 width act=%0d exp=%0d", rec_width, mq[0].w);
                end
                if (rec_sat != mq[0].s) begin
                    nfail++; $display("FAIL R5 sat act=%0b exp=%0b", rec_sat, mq[0].s);
                end
            end
            if (overflow !== m_ovf) begin
                nfail++; $display("FAIL R7 overflow act=%0b exp=%0b", overflow, m_ovf);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        check(rec_valid == 1'b0, "R10 valid after reset", int'(rec_valid), 0);
        check(overflow == 1'b0, "R10 overflow after reset", int'(overflow), 0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired act=1 exp=0");
        summary();
    end

    initial begin
        int e, k, exp_ts, n7, idx;
        bit found;
        cyc(3);
        rst = 1'b0;
        do_reset();

        // directed: kept pulse, discarded pulse, single-sample pulse
        rd_en = 1'b1;
        @(negedge clk);
        plog.delete();
        e = ecount;
        k = e + 2 + (((2 - (e + 2)) % 8) + 8) % 8;
        exp_ts = (k / 8) % 4096;
        lo_in[2] = 1'b1; lo_in[5] = 1'b1;
        cyc(16); hi_in[2] = 1'b1;
        cyc(16); hi_in[2] = 1'b0; lo_in[5] = 1'b0;
        cyc(8);  lo_in[2] = 1'b0; lo_in[0] = 1'b1; hi_in[0] = 1'b1;
        cyc(8);  lo_in[0] = 1'b0; hi_in[0] = 1'b0;
        cyc(80);
        found = 0;
        foreach (plog[i]) if (plog[i].ch == 2 && !plog[i].tr) begin
            found = 1;
            check(plog[i].ts == exp_ts, "R1 R8 lead stamp ch2", plog[i].ts, exp_ts);
            check(plog[i].w == 0, "R2 lead width ch2", plog[i].w, 0);
        end
        check(found, "R2 lead record ch2 present", int'(found), 1);
        found = 0;
        foreach (plog[i]) if (plog[i].ch == 2 && plog[i].tr) begin
            found = 1;
            check(plog[i].w == 5, "R4 width ch2", plog[i].w, 5);
            check(plog[i].ts == exp_ts + 5, "R4 trail stamp ch2", plog[i].ts, exp_ts + 5);
        end
        check(found, "R4 trail record ch2 present", int'(found), 1);
        n7 = 0;
        foreach (plog[i]) if (plog[i].ch == 5) n7++;
        check(n7 == 0, "R3 unqualified ch5 records", n7, 0);
        found = 0;
        foreach (plog[i]) if (plog[i].ch == 0 && plog[i].tr) begin
            found = 1;
            check(plog[i].w == 1, "R4 single-sample width ch0", plog[i].w, 1);
        end
        check(found, "R4 trail record ch0 present", int'(found), 1);

        // saturation and re-arm
        plog.delete();
        lo_in[7] = 1'b1; hi_in[7] = 1'b1;
        cyc(16); hi_in[7] = 1'b0;
        cyc(300 * 8 - 16); lo_in[7] = 1'b0;
        cyc(40); lo_in[7] = 1'b1; hi_in[7] = 1'b1;
        cyc(24); lo_in[7] = 1'b0; hi_in[7] = 1'b0;
        cyc(80);
        n7 = 0;
        foreach (plog[i]) if (plog[i].ch == 7 && plog[i].tr) begin
            if (n7 == 0) begin
                check(plog[i].s == 1'b1, "R5 first ch7 sat flag", int'(plog[i].s), 1);
                check(plog[i].w == SAT, "R5 first ch7 width", plog[i].w, SAT);
            end else begin
                check(plog[i].s == 1'b0, "R5 re-armed ch7 sat flag", int'(plog[i].s), 0);
                check(plog[i].w == 3, "R5 re-armed ch7 width", plog[i].w, 3);
            end
            n7++;
        end
        check(n7 == 2, "R5 ch7 trailing record count", n7, 2);

        // random traffic, long enough to wrap the event time (R8)
        for (int t = 0; t < 36000; t++) begin
            @(negedge clk);
            for (int ch = 0; ch < N; ch++) begin
                if ($urandom % 64 == 0) lo_in[ch] = ~lo_in[ch];
                hi_in[ch] = lo_in[ch] & ($urandom % 4 == 0);
            end
            rd_en = ($urandom % 4 != 0);
        end
        lo_in = '0; hi_in = '0; rd_en = 1'b1;
        cyc(100);
        check(rec_valid == 1'b0, "R9 drained after traffic", int'(rec_valid), 0);

        // overflow: fill with no reads
        do_reset();
        rd_en = 1'b0;
        for (int r = 0; r < 3; r++) begin
            lo_in = '1; hi_in = '1;
            cyc(16);
            lo_in = '0; hi_in = '0;
            cyc(16);
        end
        check(overflow == 1'b1, "R7 overflow set when full", int'(overflow), 1);
        plog.delete();
        rd_en = 1'b1;
        cyc(40);
        check(plog.size() == DEPTH, "R7 records kept when full", plog.size(), DEPTH);
        idx = 0;
        while (idx + 1 < plog.size()) begin
            check(!plog[idx].tr && plog[idx+1].tr && plog[idx].ch == plog[idx+1].ch,
                  "R6 pair adjacency", plog[idx+1].ch, plog[idx].ch);
            idx += 2;
        end
        check(overflow == 1'b1, "R7 overflow sticky after drain", int'(overflow), 1);

        summary();
    end
endmodule